// File: doc/BRIEF.md
# Falling-Edge Byte-Masked Data Memory

This block is the data memory of a core that completes one instruction per clock. The core registers its address, write data and strobes on the rising edge. The memory array and its read register are clocked on the falling edge of the same clock. A load therefore leaves registered data on the read port half a cycle later, and the data is settled before the core's next rising edge. From the core's side a load takes one cycle, even though the storage is a synchronous RAM that needs an edge of its own to read.

Stores may be one byte, a half-word or a full word. The RISC-V `funct3` width code and the two low address bits select which byte lanes are written. Lanes that are not enabled keep their contents. The lane mask is also driven out for loads, so that narrower devices outside the memory can use it. Address bit 31 marks a region that is not RAM. Reads and writes with that bit set leave the array and the read register unchanged. The read port always returns the whole word. Picking out the byte or half-word and extending its sign are left to the core.

Top module: `edge_lane_ram`

## Requirements
- R1: With width code 0 and a strobe high, `laneEn` is one-hot and is selected by `byteAddr[1:0]`: 0 gives 0001, 1 gives 0010, 2 gives 0100 and 3 gives 1000.
- R2: With width code 1 and a strobe high, `laneEn` is 1100 when `byteAddr[1]` is set and 0011 when it is clear.
- R3: With a strobe high and any width code other than 0 or 1, `laneEn` is 1111. Code 2 is a word access.
- R4: The same lane encoding is driven when only `rdStrobe` is high. `laneEn` is 0000 when both strobes are low.
- R5: The array is written on a falling edge only if `wrStrobe` is high and `byteAddr[31]` is low.
- R6: On a write, each enabled lane k takes `wrData[8k+7:8k]`. Disabled lanes keep their old bytes, so a later word load returns the new bytes merged with the untouched ones.
- R7: The word index is `byteAddr[12:2]`, giving 2048 words. Bits 30 to 13 are ignored, so addresses that differ only in those bits reach the same word.
- R8: If `rdStrobe` is high and `byteAddr[31]` is low, `rdData` takes the full 32-bit word at the index on the falling edge. The data is therefore valid before the next rising edge.
- R9: In every other case `rdData` keeps its previous value.
- R10: If a read and a write reach the same word on the same falling edge, the read returns the contents from before that write. The next read returns the new contents.
- R11: An active-low `rst_n` clears `rdData` to zero without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock. The memory works on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| widthCode | input | 3 | Access width code (0 byte, 1 half-word, other values word) |
| byteAddr | input | 32 | Byte address. Bit 31 set means the access is not to RAM. |
| wrData | input | 32 | Store data, with lane k in bits 8k+7:8k |
| wrStrobe | input | 1 | Store request |
| rdStrobe | input | 1 | Load request |
| laneEn | output | 4 | Byte-lane enables for the current access |
| rdData | output | 32 | Registered full word from the last valid load |

## Verification
On every falling edge the bound checker checks the lane-mask shape for each width code (R1 to R3) and that the mask is zero when no strobe is high (R4). It also checks that the read register holds whenever a load is not valid (R9). Only the bench's scenarios can show the array contents. These cover merged partial stores (R6), stores suppressed by bit 31 (R5), aliasing of the high index bits (R7), a load that reads the old word during a write to it (R10) and the asynchronous reset (R11).

// File: rtl/edge_lane_ram_pkg.sv
package edge_lane_ram_pkg;
  localparam int LANE_CNT = 4;
  localparam int LANE_W   = 8;
  localparam int WORD_W   = LANE_CNT * LANE_W;
  localparam int OFS_W    = $clog2(LANE_CNT);

  localparam logic [2:0] CODE_BYTE = 3'd0;
  localparam logic [2:0] CODE_HALF = 3'd1;

  typedef logic [LANE_CNT-1:0] laneMask_t;

  // strobes passed from the control to the datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    laneMask_t  lanes;
  } memStrobe_t;
endpackage

// File: rtl/edge_lane_ram_ctrl.sv
module edge_lane_ram_ctrl
  import edge_lane_ram_pkg::*;
(
  input  logic [2:0]       widthCode,
  input  logic [OFS_W-1:0] byteOfs,
  input  logic             regionHigh,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  output laneMask_t        laneEn,
  output memStrobe_t       strobes
);
  laneMask_t laneSel;

  // each lane is decided from the width code and its own offset
  for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
    localparam logic [OFS_W-1:0] K_OFS = OFS_W'(k);
    always_comb begin
      unique case (widthCode)
        CODE_BYTE: laneSel[k] = (byteOfs == K_OFS);
        CODE_HALF: laneSel[k] = (byteOfs[OFS_W-1] == K_OFS[OFS_W-1]);
        default:   laneSel[k] = 1'b1;
      endcase
    end
  end

  always_comb begin
    laneEn        = (wrStrobe || rdStrobe) ? laneSel : '0;
    strobes.wrEn  = wrStrobe && !regionHigh;
    strobes.rdEn  = rdStrobe && !regionHigh;
    strobes.lanes = laneSel;
  end
endmodule

// File: rtl/edge_lane_ram_data.sv
module edge_lane_ram_data
  import edge_lane_ram_pkg::*;
#(
  parameter int IDX_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  memStrobe_t          strobes,
  input  logic [IDX_BITS-1:0] wordIdx,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [WORD_W-1:0] memArr [DEPTH];

  // write port: falling edge, one lane at a time under its enable
  always_ff @(negedge clk) begin
    if (strobes.wrEn) begin
      for (int k = 0; k < LANE_CNT; k++) begin
        if (strobes.lanes[k])
          memArr[wordIdx][k*LANE_W +: LANE_W] <= wrData[k*LANE_W +: LANE_W];
      end
    end
  end

  // read register: falling edge, takes the word before any write on this edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      rdData <= '0;
    else if (strobes.rdEn)
      rdData <= memArr[wordIdx];
  end
endmodule

// File: rtl/edge_lane_ram.sv
module edge_lane_ram
  import edge_lane_ram_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          widthCode,
  input  logic [ADDR_W-1:0]   byteAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                wrStrobe,
  input  logic                rdStrobe,
  output logic [LANE_CNT-1:0] laneEn,
  output logic [WORD_W-1:0]   rdData
);
  localparam int IDX_LO     = OFS_W;
  localparam int IDX_HI     = IDX_LO + IDX_BITS - 1;
  localparam int REGION_BIT = ADDR_W - 1;

  memStrobe_t strobes;
  logic       unusedMidBits;

  assign unusedMidBits = ^byteAddr[REGION_BIT-1:IDX_HI+1];

  edge_lane_ram_ctrl u_ctrl (
    .widthCode  (widthCode),
    .byteOfs    (byteAddr[OFS_W-1:0]),
    .regionHigh (byteAddr[REGION_BIT]),
    .wrStrobe   (wrStrobe),
    .rdStrobe   (rdStrobe),
    .laneEn     (laneEn),
    .strobes    (strobes)
  );

  edge_lane_ram_data #(.IDX_BITS(IDX_BITS)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wordIdx (byteAddr[IDX_HI:IDX_LO]),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/edge_lane_ram_chk.sv
module edge_lane_ram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  widthCode,
  input logic [31:0] byteAddr,
  input logic        wrStrobe,
  input logic        rdStrobe,
  input logic [3:0]  laneEn,
  input logic [31:0] rdData
);
  // R1: a byte access enables exactly the lane its offset names
  p_byte_onehot_r1: assert property (@(negedge clk) disable iff (!rst_n)
    ((wrStrobe || rdStrobe) && widthCode == 3'd0)
      |-> ($onehot(laneEn) && laneEn[byteAddr[1:0]]));

  // R2: a half-word access enables the adjacent pair chosen by bit 1
  p_half_pair_r2: assert property (@(negedge clk) disable iff (!rst_n)
    ((wrStrobe || rdStrobe) && widthCode == 3'd1)
      |-> ($countones(laneEn) == 2 && laneEn[{byteAddr[1], 1'b0}]
           && laneEn[{byteAddr[1], 1'b1}]));

  // R3: every other width code enables all lanes
  p_word_all_r3: assert property (@(negedge clk) disable iff (!rst_n)
    ((wrStrobe || rdStrobe) && widthCode > 3'd1) |-> (laneEn == 4'hF));

  // R4: with no strobe, no lane is enabled
  p_idle_zero_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (!wrStrobe && !rdStrobe) |-> (laneEn == 4'h0));

  // R9: when a load is not valid, the read register holds
  p_hold_r9: assert property (@(negedge clk) disable iff (!rst_n)
    !(rdStrobe && !byteAddr[31]) |=> $stable(rdData));
endmodule

bind edge_lane_ram edge_lane_ram_chk u_chk (.*);

// File: tb/edge_lane_ram_test.sv
module edge_lane_ram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  widthCode = '0;
  logic [31:0] byteAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrStrobe = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [3:0]  laneEn;
  logic [31:0] rdData;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk; // 50 MHz

  edge_lane_ram uut (
    .clk(clk), .rst_n(rst_n), .widthCode(widthCode), .byteAddr(byteAddr),
    .wrData(wrData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .laneEn(laneEn), .rdData(rdData)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        wr;
    logic        rd;
    logic [3:0]  expLane;
    logic        chkRd;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 32'h0000_0100, 32'h1122_3344, 1'b1, 1'b0, 4'hF, 1'b0, 32'h0,         8'd3},  // R3 word store
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'h1122_3344, 8'd8},  // R8 load
    '{3'd0, 32'h0000_0101, 32'h0000_AA00, 1'b1, 1'b0, 4'h2, 1'b0, 32'h0,         8'd1},  // R1 byte 1
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'h1122_AA44, 8'd6},  // R6 merge
    '{3'd1, 32'h0000_0102, 32'hBEEF_0000, 1'b1, 1'b0, 4'hC, 1'b0, 32'h0,         8'd2},  // R2 upper half
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'hBEEF_AA44, 8'd6},
    '{3'd1, 32'h0000_0100, 32'h0000_CAFE, 1'b1, 1'b0, 4'h3, 1'b0, 32'h0,         8'd2},  // R2 lower half
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'hBEEF_CAFE, 8'd6},
    '{3'd0, 32'h0000_0103, 32'h7700_0000, 1'b1, 1'b0, 4'h8, 1'b0, 32'h0,         8'd1},  // R1 byte 3
    '{3'd0, 32'h0000_0100, 32'h0000_0055, 1'b1, 1'b0, 4'h1, 1'b0, 32'h0,         8'd1},  // R1 byte 0
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'h77EF_CA55, 8'd6},
    '{3'd2, 32'h8000_0100, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF, 1'b0, 32'h0,         8'd5},  // R5 blocked store
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'h77EF_CA55, 8'd5},
    '{3'd5, 32'h0000_0204, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'hF, 1'b0, 32'h0,         8'd3},  // R3 code 5
    '{3'd2, 32'h0000_0204, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'hDEAD_BEEF, 8'd3},
    '{3'd2, 32'h8000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'hDEAD_BEEF, 8'd9},  // R9 region read
    '{3'd0, 32'h0000_0202, 32'h0,         1'b0, 1'b0, 4'h0, 1'b1, 32'hDEAD_BEEF, 8'd4},  // R4 idle
    '{3'd0, 32'h0000_0207, 32'h0,         1'b0, 1'b1, 4'h8, 1'b1, 32'hDEAD_BEEF, 8'd4},  // R4 byte load
    '{3'd1, 32'h0000_0206, 32'h0,         1'b0, 1'b1, 4'hC, 1'b1, 32'hDEAD_BEEF, 8'd4},  // R4 half load
    '{3'd2, 32'h0000_2100, 32'h0102_0304, 1'b1, 1'b0, 4'hF, 1'b0, 32'h0,         8'd7},  // R7 alias store
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'h0102_0304, 8'd7},
    '{3'd2, 32'h0000_0100, 32'hA5A5_A5A5, 1'b1, 1'b1, 4'hF, 1'b1, 32'h0102_0304, 8'd10}, // R10 old word
    '{3'd2, 32'h0000_0100, 32'h0,         1'b0, 1'b1, 4'hF, 1'b1, 32'hA5A5_A5A5, 8'd10}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req,
                       input string what);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R11: reset state
    #25;
    check({28'h0, laneEn}, 32'h0, 4, "laneEn idle in reset");
    check(rdData, 32'h0, 11, "rdData in reset");
    @(posedge clk); #2 rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      #2;
      widthCode = VECS[i].code;
      byteAddr  = VECS[i].addr;
      wrData    = VECS[i].wd;
      wrStrobe  = VECS[i].wr;
      rdStrobe  = VECS[i].rd;
      #2;
      check({28'h0, laneEn}, {28'h0, VECS[i].expLane}, int'(VECS[i].req), "laneEn");
      @(negedge clk);
      #2;
      if (VECS[i].chkRd)
        check(rdData, VECS[i].expRd, int'(VECS[i].req), "rdData");
    end

    // R9: strobe low holds the register across several edges
    @(posedge clk); #2 wrStrobe = 1'b0; rdStrobe = 1'b0; byteAddr = 32'h0000_0204;
    repeat (3) @(negedge clk);
    #2 check(rdData, 32'hA5A5_A5A5, 9, "hold with strobes low");

    // R5 + R6: blocked byte store followed by a valid load
    @(posedge clk); #2 widthCode = 3'd0; byteAddr = 32'h8000_0101; wrData = 32'h0000_1100; wrStrobe = 1'b1;
    @(posedge clk); #2 wrStrobe = 1'b0; rdStrobe = 1'b1; widthCode = 3'd2; byteAddr = 32'h0000_0100;
    @(negedge clk); #2 check(rdData, 32'hA5A5_A5A5, 5, "region-high byte store ignored");

    // R11: asynchronous reset mid-cycle, away from any falling edge
    @(posedge clk); #3 rst_n = 1'b0;
    #1 check(rdData, 32'h0, 11, "async clear");
    @(posedge clk); #2 rst_n = 1'b1;

    // R8: data ready before the next rising edge after reset
    @(negedge clk); #2 check(rdData, 32'hA5A5_A5A5, 8, "load after reset release");

    finishRun();
  end
endmodule